// File: doc/BRIEF.md
# Tamper-Triggered Spare Register Wipe

This block holds a bank of battery-backed 32-bit spare words that software uses for backup data, and destroys that data in hardware when an external tamper input shows a chosen edge. The tamper input is synchronised to the block clock. When tamper detection is armed, the selected transition (rising or falling) zeroes every spare word in one cycle, latches a tamper status flag, and sends a single-cycle wake-up pulse to the system. The status flag drives an interrupt line only while the matching interrupt enable is set. Software clears the flag by writing 1 to it.

Software reaches the spare words, the control bits, the interrupt enable and the status flag through a simple register port. The read data is combinational from the address. The real power-domain crossing is not modelled. Instead, every spare write opens a fixed update window, and a read-only ready bit in the control register stays low for the length of that window. Software polls this bit before it trusts a read of a spare word.

Top module: `tamper_wipe_bank`

## Requirements
- R1: After synchronous reset, every spare word reads 0, the control register reads 0x80 (ready set, detection off, rising edge), the status and enable registers read 0, and irq and wake are low.
- R2: Spare word k (k = 0..19) sits at byte offset 0x40 + 4*k. All 32 bits of each word are writable and read back unchanged.
- R3: Bit 7 of the control register (offset 0x3C) is a read-only ready flag. After a write to any spare word it reads 0 for exactly four cycles and then 1. Writing that bit has no effect.
- R4: Control bit 0 arms tamper detection. Control bit 1 selects the edge: 0 means rising and 1 means falling. Both bits read back as written.
- R5: When detection is armed and the selected edge reaches the output of the two-flop synchroniser, all twenty spare words become 0.
- R6: When detection is disarmed, or when the input shows only the opposite edge, the spare words keep their values, the flag stays clear and no wake pulse occurs.
- R7: A tamper event sets bit 2 of the status register (offset 0x2C). Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R8: irq is high exactly while status bit 2 and enable bit 2 (offset 0x28) are both set.
- R9: Each tamper event produces exactly one wake pulse, one cycle long.
- R10: If a spare write lands in the same cycle as a tamper event, the wipe wins and the word reads 0.
- R11: If a write-1 to the status flag lands in the same cycle as a tamper event, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tamper_in | input | 1 | Asynchronous tamper pin |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Tamper interrupt request |
| wake | output | 1 | One-cycle wake-up pulse per tamper event |

## Verification
The hardest cases to produce are the two collisions: a spare write, or a write-1 to the flag, landing in exactly the same clock cycle that the synchronised edge is acted on. The pin change takes two synchroniser stages and one edge register to reach the wipe, so the bench changes the pin at a falling clock edge and waits two more falling edges. It then drives the register write for one cycle, which puts the write on the very rising edge where the wipe applies. It then reads the affected word and the flag through the register port.

// File: rtl/tmpw_pkg.sv
package tmpw_pkg;

    localparam int unsigned DEF_SPARE_N   = 20;
    localparam int unsigned DEF_DATA_W    = 32;
    localparam int unsigned DEF_ADDR_W    = 8;
    localparam int unsigned DEF_SYNC      = 2;
    localparam int unsigned DEF_BUSY      = 4;

    // byte offsets of the control-side registers
    localparam int unsigned OFS_IEN       = 'h28;
    localparam int unsigned OFS_ISTAT     = 'h2C;
    localparam int unsigned OFS_CTRL      = 'h3C;
    localparam int unsigned OFS_SPARE0    = 'h40;
    localparam int unsigned SPARE_STRIDE  = 4;

    // bit positions
    localparam int unsigned CTL_EN_BIT    = 0;
    localparam int unsigned CTL_EDGE_BIT  = 1;
    localparam int unsigned CTL_RDY_BIT   = 7;
    localparam int unsigned TAMP_BIT      = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic      enable;
        edge_sel_e edge_sel;
    } tamper_cfg_t;

    typedef struct packed {
        logic flag;
        logic ien;
    } tamper_irq_t;

    function automatic int unsigned spare_offset(input int unsigned k);
        return OFS_SPARE0 + SPARE_STRIDE * k;
    endfunction

endpackage

// File: rtl/tmpw_edge_detect.sv
module tmpw_edge_detect
    import tmpw_pkg::*;
#(
    parameter int unsigned STAGES = DEF_SYNC
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_i,
    input  tamper_cfg_t cfg_i,
    output logic        event_o
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            last_q <= sync_q[TOP];
        end
    end

    assign rise = sync_q[TOP] & ~last_q;
    assign fall = ~sync_q[TOP] & last_q;

    always_comb begin
        event_o = 1'b0;
        if (cfg_i.enable) begin
            event_o = (cfg_i.edge_sel == EDGE_FALL) ? fall : rise;
        end
    end

    // R5: an event needs the synchronised level to have just moved
    a_r5_event_on_change: assert property (@(posedge clk) disable iff (rst)
        event_o |-> !$stable(sync_q[TOP]));

endmodule

// File: rtl/tmpw_spare_bank.sv
module tmpw_spare_bank
    import tmpw_pkg::*;
#(
    parameter int unsigned N    = DEF_SPARE_N,
    parameter int unsigned W    = DEF_DATA_W,
    parameter int unsigned BUSY = DEF_BUSY
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wipe_i,
    input  logic                wr_i,
    input  logic [N-1:0]        sel_i,
    input  logic [W-1:0]        wdata_i,
    output logic [N-1:0][W-1:0] bank_o,
    output logic                ready_o
);
    localparam int unsigned CNT_W = $clog2(BUSY + 1);

    logic [CNT_W-1:0] busy_q;
    logic             any_wr;

    assign any_wr = wr_i & (|sel_i);

    for (genvar k = 0; k < N; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || wipe_i) begin
                bank_o[k] <= '0;
            end else if (wr_i && sel_i[k]) begin
                bank_o[k] <= wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
        end else if (any_wr) begin
            busy_q <= CNT_W'(BUSY);
        end else if (busy_q != '0) begin
            busy_q <= busy_q - 1'b1;
        end
    end

    assign ready_o = (busy_q == '0);

    // R5/R10: a wipe leaves every word at zero, whatever else was written
    a_r5_wipe_clears: assert property (@(posedge clk) disable iff (rst)
        wipe_i |=> (bank_o == '0));

    // R3: a spare write always opens the update window
    a_r3_ready_drops: assert property (@(posedge clk) disable iff (rst)
        any_wr |=> !ready_o);

    // R3: the window counter never exceeds its length
    a_r3_window_bound: assert property (@(posedge clk) disable iff (rst)
        busy_q <= CNT_W'(BUSY));

endmodule

// File: rtl/tmpw_irq_ctrl.sv
module tmpw_irq_ctrl
    import tmpw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic event_i,
    input  logic clr_i,
    input  logic ien_i,
    output logic flag_o,
    output logic irq_o,
    output logic wake_o
);
    tamper_irq_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            wake_o <= event_i;
            if (event_i) begin
                flag_o <= 1'b1;
            end else if (clr_i) begin
                flag_o <= 1'b0;
            end
        end
    end

    assign st.flag = flag_o;
    assign st.ien  = ien_i;
    assign irq_o   = st.flag & st.ien;

    // R7/R11: an event always leaves the flag set
    a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
        event_i |=> flag_o);

    // R9: every wake pulse follows an event
    a_r9_wake_source: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> $past(event_i));

    // R7: the flag only rises because of an event
    a_r7_flag_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> $past(event_i));

endmodule

// File: rtl/tamper_wipe_bank.sv
module tamper_wipe_bank
    import tmpw_pkg::*;
#(
    parameter int unsigned SPARE_N     = DEF_SPARE_N,
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC,
    parameter int unsigned BUSY_CYCLES = DEF_BUSY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tamper_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              wake
);
    tamper_cfg_t                    cfg_q;
    logic                           ien_q;
    logic                           evt;
    logic                           flag;
    logic                           ready;
    logic [SPARE_N-1:0]             sel;
    logic [SPARE_N-1:0][DATA_W-1:0] bank;
    logic                           hit_ctrl;
    logic                           hit_ien;
    logic                           hit_istat;
    logic                           clr_flag;

    assign hit_ctrl  = (reg_addr == ADDR_W'(OFS_CTRL));
    assign hit_ien   = (reg_addr == ADDR_W'(OFS_IEN));
    assign hit_istat = (reg_addr == ADDR_W'(OFS_ISTAT));

    for (genvar k = 0; k < SPARE_N; k++) begin : g_dec
        assign sel[k] = (reg_addr == ADDR_W'(spare_offset(k)));
    end

    assign clr_flag = reg_wr & hit_istat & reg_wdata[TAMP_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            ien_q <= 1'b0;
        end else if (reg_wr) begin
            if (hit_ctrl) begin
                cfg_q.enable   <= reg_wdata[CTL_EN_BIT];
                cfg_q.edge_sel <= edge_sel_e'(reg_wdata[CTL_EDGE_BIT]);
            end
            if (hit_ien) begin
                ien_q <= reg_wdata[TAMP_BIT];
            end
        end
    end

    tmpw_edge_detect #(
        .STAGES (SYNC_STAGES)
    ) edge_i (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (tamper_in),
        .cfg_i   (cfg_q),
        .event_o (evt)
    );

    tmpw_spare_bank #(
        .N    (SPARE_N),
        .W    (DATA_W),
        .BUSY (BUSY_CYCLES)
    ) bank_i (
        .clk     (clk),
        .rst     (rst),
        .wipe_i  (evt),
        .wr_i    (reg_wr),
        .sel_i   (sel),
        .wdata_i (reg_wdata),
        .bank_o  (bank),
        .ready_o (ready)
    );

    tmpw_irq_ctrl irq_i (
        .clk     (clk),
        .rst     (rst),
        .event_i (evt),
        .clr_i   (clr_flag),
        .ien_i   (ien_q),
        .flag_o  (flag),
        .irq_o   (irq),
        .wake_o  (wake)
    );

    always_comb begin
        reg_rdata = '0;
        if (hit_ctrl) begin
            reg_rdata[CTL_EN_BIT]   = cfg_q.enable;
            reg_rdata[CTL_EDGE_BIT] = cfg_q.edge_sel;
            reg_rdata[CTL_RDY_BIT]  = ready;
        end
        if (hit_ien) begin
            reg_rdata[TAMP_BIT] = ien_q;
        end
        if (hit_istat) begin
            reg_rdata[TAMP_BIT] = flag;
        end
        for (int k = 0; k < SPARE_N; k++) begin
            if (sel[k]) begin
                reg_rdata = bank[k];
            end
        end
    end

    // R8: the interrupt line never rises without an enabled, set flag
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag && ien_q));

    // R4: control bits only move on a control write
    a_r4_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && hit_ctrl) |=> $stable(cfg_q));

endmodule

// File: tb/tamper_wipe_bank_tb_top.sv
module tamper_wipe_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSP = 20;

    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 wake
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tamper_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        wake;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    wake_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tamper_wipe_bank dut_i (
        .clk       (clk),
        .rst       (rst),
        .tamper_in (tamper_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .wake      (wake)
    );

    always @(negedge clk) if (!rst && wake) wake_cnt++;

    // monitor: pops every item pushed at this falling edge
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                1:       act = {31'b0, irq};
                2:       act = {31'b0, wake};
                default: act = reg_rdata;
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    function automatic logic [31:0] pat(input int k, input int salt);
        return 32'hA5C3_0F00 ^ (32'(k) * 32'h0101_0101) ^ (32'(salt) << 16);
    endfunction

    function automatic logic [7:0] sp(input int k);
        return 8'(8'h40 + 4 * k);
    endfunction

    // driver: expected read, checked at this falling edge
    task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.kind = 0; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic exp_pin(input int kind, input logic e, input string tag);
        item_t it;
        it.kind = kind; it.exp = {31'b0, e}; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pin change; returns in the cycle whose rising edge applies the event
    task automatic pin_set(input logic v);
        tamper_in = v;
        idle(2);
    endtask

    task automatic chk(input string tag, input int act, input int e);
        n_chk++;
        if (act != e) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, e);
        end
    endtask

    task automatic fill(input int salt);
        for (int k = 0; k < NSP; k++) wr(sp(k), pat(k, salt));
        idle(5);
    endtask

    initial begin
        int w0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        exp_rd(sp(0), 32'h0, "R1 spare0");
        exp_rd(sp(19), 32'h0, "R1 spare19");
        exp_rd(8'h3C, 32'h80, "R1 ctrl");
        exp_rd(8'h2C, 32'h0, "R1 status");
        exp_rd(8'h28, 32'h0, "R1 enable");
        exp_pin(1, 1'b0, "R1 irq");
        exp_pin(2, 1'b0, "R1 wake");

        // R2 full-width read/write of every word
        fill(1);
        for (int k = 0; k < NSP; k++) exp_rd(sp(k), pat(k, 1), "R2 readback");

        // R3 ready window of four cycles
        wr(sp(3), 32'hFFFF_FFFF);
        exp_rd(8'h3C, 32'h0, "R3 busy c1");
        exp_rd(8'h3C, 32'h0, "R3 busy c2");
        exp_rd(8'h3C, 32'h0, "R3 busy c3");
        exp_rd(8'h3C, 32'h0, "R3 busy c4");
        exp_rd(8'h3C, 32'h80, "R3 ready again");
        exp_rd(sp(3), 32'hFFFF_FFFF, "R2 all ones");
        wr(sp(4), 32'h0);
        wr(8'h3C, 32'h80);
        exp_rd(8'h3C, 32'h0, "R3 ready not writable");
        idle(5);

        // R4 control bits
        wr(8'h3C, 32'h3);
        exp_rd(8'h3C, 32'h83, "R4 enable+falling");
        wr(8'h3C, 32'h0);
        exp_rd(8'h3C, 32'h80, "R4 cleared");

        fill(2);
        w0 = wake_cnt;
        // R6 disarmed: pulses do nothing
        pin_set(1'b1); idle(3);
        pin_set(1'b0); idle(3);
        exp_rd(sp(7), pat(7, 2), "R6 disarmed keeps data");
        exp_rd(8'h2C, 32'h0, "R6 disarmed no flag");
        chk("R6 disarmed no wake", wake_cnt - w0, 0);

        // R6 armed for falling, rising edge ignored
        wr(8'h3C, 32'h3);
        pin_set(1'b1); idle(3);
        exp_rd(sp(0), pat(0, 2), "R6 opposite edge keeps data");
        exp_rd(8'h2C, 32'h0, "R6 opposite edge no flag");
        chk("R6 opposite edge no wake", wake_cnt - w0, 0);

        // R5 falling edge wipes
        pin_set(1'b0); idle(3);
        for (int k = 0; k < NSP; k++) exp_rd(sp(k), 32'h0, "R5 falling wipe");
        exp_rd(8'h2C, 32'h4, "R7 flag set");
        exp_pin(1, 1'b0, "R8 irq masked");
        chk("R9 one wake pulse", wake_cnt - w0, 1);

        // R8 / R7 gating and clearing
        wr(8'h28, 32'h4);
        exp_pin(1, 1'b1, "R8 irq enabled");
        wr(8'h2C, 32'h0);
        exp_rd(8'h2C, 32'h4, "R7 write 0 keeps flag");
        wr(8'h2C, 32'h4);
        exp_rd(8'h2C, 32'h0, "R7 w1c clears");
        exp_pin(1, 1'b0, "R8 irq drops");

        // R5 rising edge wipes
        fill(3);
        wr(8'h3C, 32'h1);
        w0 = wake_cnt;
        pin_set(1'b1); idle(3);
        exp_rd(sp(11), 32'h0, "R5 rising wipe");
        exp_rd(sp(19), 32'h0, "R5 rising wipe last");
        exp_pin(1, 1'b1, "R8 irq on event");
        chk("R9 one wake pulse rising", wake_cnt - w0, 1);

        // R10 write collides with wipe
        wr(8'h2C, 32'h4);
        pin_set(1'b0); idle(3);
        wr(sp(5), 32'h1234_5678); idle(5);
        exp_rd(sp(5), 32'h1234_5678, "R10 setup");
        pin_set(1'b1);
        wr(sp(5), 32'hDEAD_BEEF);
        idle(5);
        exp_rd(sp(5), 32'h0, "R10 wipe wins");

        // R11 w1c collides with event
        wr(8'h2C, 32'h4);
        exp_rd(8'h2C, 32'h0, "R11 setup");
        pin_set(1'b0); idle(3);
        pin_set(1'b1);
        wr(8'h2C, 32'h4);
        idle(2);
        exp_rd(8'h2C, 32'h4, "R11 set wins");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule